// File: doc/BRIEF.md
# Mains Phase-Angle Firing Controller

This block drives the gates of triacs or thyristors so that each one turns on at a chosen delay after a mains zero crossing and stays on until that half-cycle ends. A zero-cross detector delivers one pulse per half-cycle, which is 120 pulses per second on 60 Hz mains. The block lines that pulse up with the crossing the power device actually sees by adding a configurable offset. A single lag command then sets how long after the corrected crossing firing begins. A longer lag delivers less power to the load. Speed regulation and feedback belong to other blocks, which compute the lag.

All timing runs on a fixed tick taken from the clock by a divider. The block measures the interval between sync edges in ticks and treats that interval as the expected half-period. It uses the measurement both to clamp firing before the next crossing and to detect a sync source that has gone silent. With one gate output, every half-cycle fires the same device. With two, three or six outputs, successive half-cycles are handed to the outputs in a fixed rotation.

Top module: `phase_fire_ctrl`

## Requirements
- R1: Only a rising edge of `sync_in` starts a new half-cycle. The edge takes effect three clocks after the input rises: two synchronising flops, then the state register. A falling edge, wherever it lands in the half-cycle, changes nothing.
- R2: The half-period in ticks is the interval between the last two rising sync edges. Until two consecutive edges have been seen with no loss between them, every gate stays low.
- R3: After the edge, a tick count runs up from 0. The active gate is high while that count is at least `offset_cfg + lag_cmd` and below the measured half-period. It drops when the next rising sync edge arrives.
- R4: A lag of zero fires the active gate from tick `offset_cfg` onward. With offset zero as well, the gate conducts for the whole half-cycle, starting at count 0.
- R5: When `offset_cfg + lag_cmd` is at or above the measured half-period, no gate fires during that half-cycle.
- R6: `lag_cmd` and `offset_cfg` are captured only at a rising sync edge. A change made during a half-cycle applies from the next half-cycle on.
- R7: The gate index used in a half-cycle is the number of sync edges since reset, modulo N_OUT, so the first edge after reset selects index 1 when N_OUT > 1. Bit i of `gate_o` is gate i. At most one gate is high at a time.
- R8: Loss is flagged when, with a valid half-period, the tick count since the last edge exceeds the half-period plus half of it (rounded down). `sync_lost_o` then goes high, which happens on the clock where the count reaches that limit plus one, and all gates go low. The next rising edge clears the flag. Firing resumes only after one further full half-cycle has been measured.
- R9: After reset, `gate_o` is all zero and `sync_lost_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | Zero-cross pulse, asynchronous to clk |
| lag_cmd | input | TW | Firing lag after the corrected crossing, in ticks |
| offset_cfg | input | TW | Delay from the sync edge to the true crossing, in ticks |
| gate_o | output | N_OUT | Gate drive, one bit per power device |
| sync_lost_o | output | 1 | High while the sync pulses are missing |

## Verification
The bench builds the block with N_OUT = 3, TW = 12 and a tick of one clock. This makes every tick count equal a clock count, so the expected firing windows can be placed exactly. The three-way rotation exercises the wrap of the gate index, which a single output would leave untouched. The 12-bit counters allow half-periods of 24 to 60 ticks. A silence of more than 1.5 half-periods is reached in well under a hundred clocks, so the loss limit and its clearing can be hit on the exact tick.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    // Largest gate count the rotation supports (six-device bridge).
    localparam int unsigned PFC_MAX_GATES = 6;

    // Next position in the rotating gate order.
    function automatic int unsigned pfc_next_slot(input int unsigned cur, input int unsigned n);
        if (cur + 1 >= n)
            return 0;
        return cur + 1;
    endfunction

endpackage

// File: rtl/pfc_tick_gen.sv
module pfc_tick_gen #(
    parameter int unsigned TICK_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_every_clock
            assign tick = 1'b1;
        end else begin : g_divided
            localparam int unsigned CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
            localparam logic [CW-1:0] ONE  = CW'(1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                if (cnt_q == LAST)
                    cnt_d = '0;
                else
                    cnt_d = cnt_q + ONE;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_d;
            end

            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/pfc_sync_edge.sv
module pfc_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [2:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pipe_q <= '0;
        else
            pipe_q <= pipe_d;
    end

    // pipe_q[1] is the synchronised level, pipe_q[2] its previous value
    assign rise = pipe_q[1] & ~pipe_q[2];
endmodule

// File: rtl/pfc_gate_decode.sv
module pfc_gate_decode #(
    parameter int unsigned N_OUT = 1,
    parameter int unsigned SW    = 1
) (
    input  logic          fire,
    input  logic [SW-1:0] slot,
    output logic [N_OUT-1:0] gate
);
    generate
        for (genvar g = 0; g < N_OUT; g++) begin : g_gate
            assign gate[g] = fire && (slot == SW'(g));
        end
    endgenerate
endmodule

// File: rtl/phase_fire_ctrl.sv
module phase_fire_ctrl
    import pfc_pkg::*;
#(
    parameter int unsigned N_OUT    = 1,
    parameter int unsigned TW       = 16,
    parameter int unsigned TICK_DIV = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic [TW-1:0]    lag_cmd,
    input  logic [TW-1:0]    offset_cfg,
    output logic [N_OUT-1:0] gate_o,
    output logic             sync_lost_o
);
    localparam int unsigned SW = (N_OUT > 1) ? $clog2(N_OUT) : 1;
    localparam logic [TW-1:0] PH_ONE = TW'(1);
    localparam logic [TW-1:0] PH_MAX = '1;

    typedef struct packed {
        logic [TW-1:0] phase;   // ticks since last rising sync edge
        logic [TW-1:0] period;  // measured half-period
        logic [TW:0]   start;   // offset + lag captured at the edge
        logic [SW-1:0] slot;    // active gate index
        logic          seen;    // at least one edge since reset
        logic          valid;   // period is trustworthy
        logic          lost;    // sync missing
        logic          fire;    // active gate is on
    } pfc_state_t;

    pfc_state_t st_d, st_q;
    logic       tick;
    logic       sync_rise;
    logic [TW:0] loss_limit;

    pfc_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pfc_sync_edge edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sync_in),
        .rise     (sync_rise)
    );

    assign loss_limit = {1'b0, st_q.period} + {2'b00, st_q.period[TW-1:1]};

    always_comb begin
        st_d = st_q;

        if (tick && st_q.phase != PH_MAX)
            st_d.phase = st_q.phase + PH_ONE;

        if (sync_rise) begin
            st_d.phase  = '0;
            st_d.period = (st_q.phase == PH_MAX) ? PH_MAX : st_q.phase + PH_ONE;
            st_d.start  = {1'b0, offset_cfg} + {1'b0, lag_cmd};
            st_d.slot   = SW'(pfc_next_slot(32'(st_q.slot), N_OUT));
            st_d.seen   = 1'b1;
            st_d.valid  = st_q.seen & ~st_q.lost;
            st_d.lost   = 1'b0;
        end else if (st_q.valid && ({1'b0, st_d.phase} > loss_limit)) begin
            st_d.lost   = 1'b1;
        end

        st_d.fire = st_d.valid
                  & ~st_d.lost
                  & (st_d.start < {1'b0, st_d.period})
                  & ({1'b0, st_d.phase} >= st_d.start)
                  & (st_d.phase < st_d.period);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    pfc_gate_decode #(.N_OUT(N_OUT), .SW(SW)) dec_i (
        .fire (st_q.fire),
        .slot (st_q.slot),
        .gate (gate_o)
    );

    assign sync_lost_o = st_q.lost;

    // Plain views of state for the bound checker
    logic          mon_valid;
    logic [TW:0]   mon_start;
    logic [SW-1:0] mon_slot;
    assign mon_valid = st_q.valid;
    assign mon_start = st_q.start;
    assign mon_slot  = st_q.slot;
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
    parameter int unsigned N_OUT = 1,
    parameter int unsigned TW    = 16,
    parameter int unsigned SW    = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rise,
    input logic [N_OUT-1:0] gate,
    input logic             lost,
    input logic             valid,
    input logic [TW:0]      start,
    input logic [SW-1:0]    slot
);
    AST_ONE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate)); // R7

    AST_LOST_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> (gate == '0)); // R8

    AST_EDGE_CLEARS_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !lost); // R8

    AST_UNMEASURED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (gate == '0)); // R2

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(start)); // R6

    AST_SLOT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && N_OUT > 1) |=> (slot != $past(slot))); // R7
endmodule

bind phase_fire_ctrl pfc_checker #(.N_OUT(N_OUT), .TW(TW), .SW(SW)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .rise  (sync_rise),
    .gate  (gate_o),
    .lost  (sync_lost_o),
    .valid (mon_valid),
    .start (mon_start),
    .slot  (mon_slot)
);

// File: tb/phase_fire_ctrl_tb.sv
`timescale 1ns/1ps
module phase_fire_ctrl_tb_top;
    localparam int N  = 3;
    localparam int TW = 12;
    localparam int NV = 8;
    // {half-period, lag, offset}
    localparam int VEC [NV][3] = '{
        '{40, 0, 0}, '{40, 10, 5}, '{40, 30, 9}, '{40, 35, 5},
        '{60, 20, 0}, '{50, 100, 0}, '{30, 0, 12}, '{24, 3, 4}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_in = 1'b0;
    logic [TW-1:0] lag_cmd = '0;
    logic [TW-1:0] offset_cfg = '0;
    logic [N-1:0]  gate;
    logic          lost;

    int n_cmp = 0;
    int n_bad = 0;
    int edges = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    phase_fire_ctrl #(.N_OUT(N), .TW(TW), .TICK_DIV(1)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_in     (sync_in),
        .lag_cmd     (lag_cmd),
        .offset_cfg  (offset_cfg),
        .gate_o      (gate),
        .sync_lost_o (lost)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One half-cycle of p clocks; sync rises at step 0, falls at step hi.
    // mode 0: no check, 1: firing window from 'start', 2: all gates low.
    task automatic run_half(input int p, input int hi, input int mode, input int start,
                            input int chg_at, input int chg_val, input string tag);
        int slot;
        int k;
        int exp;
        edges++;
        slot = edges % N;
        for (int i = 0; i < p; i++) begin
            if (i == 0) sync_in = 1'b1;
            if (i == hi) sync_in = 1'b0;
            if (i == chg_at) lag_cmd = TW'(chg_val);
            @(negedge clk);
            k = i - 2;
            if (k >= 0 && mode == 1) begin
                exp = (k >= start && start < p) ? (1 << slot) : 0;
                check_val($sformatf("%s k=%0d gate", tag, k), int'(gate), exp);
            end else if (k >= 0 && mode == 2) begin
                check_val($sformatf("%s k=%0d quiet gate", tag, k), int'(gate), 0);
                if (k == 0) check_val($sformatf("%s lost at edge", tag), int'(lost), 0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R9 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check_val("R9 reset gate", int'(gate), 0);
        check_val("R9 reset lost", int'(lost), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: nothing fires before a half-period is measured; R4: then full conduction
        run_half(40, 2, 2, 0, -1, 0, "R2");
        run_half(40, 2, 1, 0, -1, 0, "R4");

        // R1: a late falling edge does not restart the half-cycle
        lag_cmd = TW'(10);
        run_half(40, 2, 0, 0, -1, 0, "R1");
        run_half(40, 30, 1, 10, -1, 0, "R1");

        // R6: change mid-cycle applies only to the next half-cycle
        lag_cmd = TW'(5);
        run_half(40, 2, 0, 0, -1, 0, "R6");
        run_half(40, 2, 1, 5, 8, 25, "R6");
        run_half(40, 2, 1, 25, -1, 0, "R6");

        // R8: silence; loss flagged at count 61 for a 40-tick half-period
        for (int m = 1; m <= 24; m++) begin
            @(negedge clk);
            if (37 + m == 60) check_val("R8 lost before limit", int'(lost), 0);
            if (37 + m == 61) begin
                check_val("R8 lost at limit", int'(lost), 1);
                check_val("R8 gate while lost", int'(gate), 0);
            end
        end
        run_half(40, 2, 2, 0, -1, 0, "R8");
        run_half(40, 2, 1, 25, -1, 0, "R8");

        // Table walk: R3 window, R4 zero lag, R5 suppression, R7 rotation
        for (int v = 0; v < NV; v++) begin
            int p;
            int st;
            string tag;
            p  = VEC[v][0];
            st = VEC[v][1] + VEC[v][2];
            lag_cmd    = TW'(VEC[v][1]);
            offset_cfg = TW'(VEC[v][2]);
            if (st >= p)          tag = $sformatf("R5 vec%0d", v);
            else if (VEC[v][1] == 0) tag = $sformatf("R4 vec%0d", v);
            else                  tag = $sformatf("R3 R7 vec%0d", v);
            run_half(p, 2, 0, 0, -1, 0, tag);
            run_half(p, 2, 0, 0, -1, 0, tag);
            run_half(p, 2, 1, st, -1, 0, tag);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule